// File: doc/BRIEF.md
# Ternary Classifier Matcher and Message Builder

This block holds one production rule made of two conditions and one action. Each is a string of symbols drawn from zero, one and don't-care, and each symbol is stored as a two-bit code. When a start strobe arrives, a binary message is compared with both conditions in parallel. The rule is flagged active only when every symbol of both conditions accepts the matching message bit.

In the same step the block builds an outgoing message from the action template. Fixed action symbols are copied to the output. A don't-care action symbol passes the matching message bit through unchanged. The block also reports a specificity figure, which counts the symbols that are not don't-care across all three stored strings.

Results are registered at the start edge and marked by a one-cycle valid pulse. A single load port writes any of the three strings. Deciding which rules win, and storing messages, are left to neighbouring logic.

Top module: `ternary_matcher`

## Requirements
- R1: Symbol codes are zero = 2'b01, one = 2'b10, don't-care = 2'b11. Symbol i of a string sits at bits [2i+1:2i] of `loadData`. When `loadEn` is high, `loadSel` 0 writes condition A, 1 writes condition B and 2 writes the action, each at the clock edge.
- R2: A condition symbol accepts message bit 0 exactly when its low code bit is 1, and accepts message bit 1 exactly when its high code bit is 1. A don't-care therefore accepts either value.
- R3: `active` is 1 only when every symbol of condition A and every symbol of condition B accepts its message bit. Otherwise it is 0.
- R4: A stored code 2'b00 in a condition never accepts any message bit.
- R5: Bit i of `newMsg` equals the action symbol's value when that symbol is zero or one. It equals message bit i when the symbol is don't-care. It is 0 when the symbol is 2'b00.
- R6: `active`, `newMsg` and `specificity` are captured at the clock edge where `start` is high. `outValid` is high for exactly the following cycle. Between starts the outputs hold their values.
- R7: `specificity` equals the number of stored symbols whose code is not 2'b11, counted over condition A, condition B and the action. Its range is 0 to 3*SYMS.
- R8: When a load and a start fall in the same cycle, the result is computed from the contents held before that load.
- R9: After reset, `outValid`, `active`, `newMsg` and `specificity` are 0, and all three stored strings are all don't-care.
- R10: A load with `loadSel` = 3 changes none of the stored strings.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| loadEn | input | 1 | Write strobe for the stored strings |
| loadSel | input | 2 | Selects the string to write: 0 cond A, 1 cond B, 2 action, 3 none |
| loadData | input | 2*SYMS | Symbol codes to write, two bits per symbol |
| start | input | 1 | Starts a match and build on the current message |
| msgIn | input | SYMS | Binary message to match |
| outValid | output | 1 | One-cycle pulse marking fresh results |
| active | output | 1 | Both conditions matched |
| newMsg | output | SYMS | Message built from the action template |
| specificity | output | $clog2(3*SYMS+1) | Count of non-don't-care stored symbols |

## Verification
A load and a start can land on the same clock edge. The question is then whether the match reads the string being replaced or the new one. The bench raises `loadEn` and `start` together, writing a condition that would reject the message. It expects the first result to use the old contents, which still match, and a second start to reflect the new string.

// File: rtl/tcm_pkg.sv
package tcm_pkg;
  localparam logic [1:0] SYM_ZERO = 2'b01;
  localparam logic [1:0] SYM_ONE  = 2'b10;
  localparam logic [1:0] SYM_ANY  = 2'b11;

  localparam logic [1:0] SEL_COND_A = 2'd0;
  localparam logic [1:0] SEL_COND_B = 2'd1;
  localparam logic [1:0] SEL_ACTION = 2'd2;

  typedef struct packed {
    logic capture;
    logic wrCondA;
    logic wrCondB;
    logic wrAct;
  } tcmStrobes_t;
endpackage

// File: rtl/tcm_ctrl.sv
module tcm_ctrl
  import tcm_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        start,
  input  logic        loadEn,
  input  logic [1:0]  loadSel,
  output tcmStrobes_t strobes,
  output logic        outValid
);

  always_comb begin
    strobes.capture = start;
    strobes.wrCondA = loadEn && (loadSel == SEL_COND_A);
    strobes.wrCondB = loadEn && (loadSel == SEL_COND_B);
    strobes.wrAct   = loadEn && (loadSel == SEL_ACTION);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) outValid <= 1'b0;
    else       outValid <= start;
  end

  AST_ONE_WRITE: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({strobes.wrCondA, strobes.wrCondB, strobes.wrAct})); // R1
  AST_NO_WRITE_SEL3: assert property (@(posedge clk) disable iff (!rstN)
    (loadSel == 2'd3) |-> !(strobes.wrCondA || strobes.wrCondB || strobes.wrAct)); // R10

endmodule

// File: rtl/tcm_datapath.sv
module tcm_datapath
  import tcm_pkg::*;
#(
  parameter int SYMS = 8,
  localparam int CODEW = 2 * SYMS,
  localparam int CNTW = $clog2(3 * SYMS + 1)
) (
  input  logic             clk,
  input  logic             rstN,
  input  tcmStrobes_t      strobes,
  input  logic [CODEW-1:0] loadData,
  input  logic [SYMS-1:0]  msgIn,
  output logic             active,
  output logic [SYMS-1:0]  newMsg,
  output logic [CNTW-1:0]  specificity
);

  logic [CODEW-1:0] condA, condB, action;
  logic [SYMS-1:0]  matchA, matchB, buildBit, actIsAny, illegalCond;
  logic [3*SYMS-1:0] specificSym;
  logic [CNTW-1:0]  specCount;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      condA  <= '1;
      condB  <= '1;
      action <= '1;
    end else begin
      if (strobes.wrCondA) condA  <= loadData;
      if (strobes.wrCondB) condB  <= loadData;
      if (strobes.wrAct)   action <= loadData;
    end
  end

  for (genvar i = 0; i < SYMS; i++) begin : g_sym
    logic [1:0] symA, symB, symX;
    assign symA = condA[2*i +: 2];
    assign symB = condB[2*i +: 2];
    assign symX = action[2*i +: 2];
    // message bit 1 searches the high code bit, bit 0 the low one
    assign matchA[i]      = msgIn[i] ? symA[1] : symA[0];
    assign matchB[i]      = msgIn[i] ? symB[1] : symB[0];
    assign actIsAny[i]    = (symX == SYM_ANY);
    assign buildBit[i]    = actIsAny[i] ? msgIn[i] : symX[1];
    assign illegalCond[i] = (symA == 2'b00) || (symB == 2'b00);
    assign specificSym[i]          = (symA != SYM_ANY);
    assign specificSym[SYMS + i]   = (symB != SYM_ANY);
    assign specificSym[2*SYMS + i] = !actIsAny[i];
  end

  always_comb begin
    specCount = '0;
    for (int j = 0; j < 3 * SYMS; j++) specCount = specCount + CNTW'(specificSym[j]);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      active      <= 1'b0;
      newMsg      <= '0;
      specificity <= '0;
    end else if (strobes.capture) begin
      active      <= (&matchA) && (&matchB);
      newMsg      <= buildBit;
      specificity <= specCount;
    end
  end

  AST_ILLEGAL_NOMATCH: assert property (@(posedge clk) disable iff (!rstN)
    (strobes.capture && (|illegalCond)) |=> !active); // R4
  AST_HASH_PASSTHRU: assert property (@(posedge clk) disable iff (!rstN)
    (strobes.capture && (&actIsAny)) |=> (newMsg == $past(msgIn))); // R5
  AST_HOLD_IDLE: assert property (@(posedge clk) disable iff (!rstN)
    !strobes.capture |=> $stable({active, newMsg, specificity})); // R6
  AST_SPEC_RANGE: assert property (@(posedge clk) disable iff (!rstN)
    specificity <= CNTW'(3 * SYMS)); // R7

endmodule

// File: rtl/ternary_matcher.sv
module ternary_matcher
  import tcm_pkg::*;
#(
  parameter int SYMS = 8,
  localparam int CODEW = 2 * SYMS,
  localparam int CNTW = $clog2(3 * SYMS + 1)
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             loadEn,
  input  logic [1:0]       loadSel,
  input  logic [CODEW-1:0] loadData,
  input  logic             start,
  input  logic [SYMS-1:0]  msgIn,
  output logic             outValid,
  output logic             active,
  output logic [SYMS-1:0]  newMsg,
  output logic [CNTW-1:0]  specificity
);

  tcmStrobes_t strobes;

  tcm_ctrl i_ctrl (
    .clk(clk), .rstN(rstN), .start(start), .loadEn(loadEn),
    .loadSel(loadSel), .strobes(strobes), .outValid(outValid)
  );

  tcm_datapath #(.SYMS(SYMS)) i_datapath (
    .clk(clk), .rstN(rstN), .strobes(strobes), .loadData(loadData),
    .msgIn(msgIn), .active(active), .newMsg(newMsg), .specificity(specificity)
  );

endmodule

// File: tb/test_ternary_matcher.sv
`timescale 1ns/1ps
module test_ternary_matcher;
  localparam int SYMS = 8;
  localparam int CODEW = 2 * SYMS;
  localparam int CNTW = $clog2(3 * SYMS + 1);

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic loadEn = 1'b0;
  logic [1:0] loadSel = 2'd0;
  logic [CODEW-1:0] loadData = '0;
  logic start = 1'b0;
  logic [SYMS-1:0] msgIn = '0;
  logic outValid, active;
  logic [SYMS-1:0] newMsg;
  logic [CNTW-1:0] specificity;

  int errors = 0;
  int checks = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  ternary_matcher #(.SYMS(SYMS)) i_ternary_matcher (
    .clk(clk), .rstN(rstN), .loadEn(loadEn), .loadSel(loadSel),
    .loadData(loadData), .start(start), .msgIn(msgIn), .outValid(outValid),
    .active(active), .newMsg(newMsg), .specificity(specificity)
  );

  // fields: aCare aVal bCare bVal xCare xVal msg (care=1 -> fixed symbol)
  localparam logic [55:0] VEC [6] = '{
    {8'hFF, 8'hA5, 8'h00, 8'h00, 8'hFF, 8'h3C, 8'hA5},
    {8'hFF, 8'hA5, 8'h00, 8'h00, 8'hFF, 8'h3C, 8'hA4},
    {8'h0F, 8'h05, 8'hF0, 8'h30, 8'h00, 8'h00, 8'h35},
    {8'h00, 8'h00, 8'h00, 8'h00, 8'hF0, 8'h90, 8'h0F},
    {8'h00, 8'h00, 8'h01, 8'h01, 8'h0F, 8'h0A, 8'h00},
    {8'hFF, 8'h00, 8'hFF, 8'h00, 8'hFF, 8'hFF, 8'h00}
  };

  function automatic logic [CODEW-1:0] enc(input logic [7:0] care, input logic [7:0] val);
    logic [CODEW-1:0] r;
    for (int i = 0; i < SYMS; i++)
      r[2*i +: 2] = !care[i] ? 2'b11 : (val[i] ? 2'b10 : 2'b01);
    return r;
  endfunction

  function automatic bit symOk(input logic [1:0] c, input logic m);
    return (c == 2'b11) || (c == 2'b10 && m) || (c == 2'b01 && !m);
  endfunction

  function automatic bit modelActive(input logic [CODEW-1:0] a, b, input logic [SYMS-1:0] m);
    bit ok = 1'b1;
    for (int i = 0; i < SYMS; i++)
      if (!symOk(a[2*i +: 2], m[i]) || !symOk(b[2*i +: 2], m[i])) ok = 1'b0;
    return ok;
  endfunction

  function automatic logic [SYMS-1:0] modelMsg(input logic [CODEW-1:0] x, input logic [SYMS-1:0] m);
    logic [SYMS-1:0] r;
    for (int i = 0; i < SYMS; i++) begin
      case (x[2*i +: 2])
        2'b11:   r[i] = m[i];
        2'b10:   r[i] = 1'b1;
        default: r[i] = 1'b0;
      endcase
    end
    return r;
  endfunction

  function automatic int modelSpec(input logic [CODEW-1:0] a, b, x);
    int n = 0;
    for (int i = 0; i < SYMS; i++) begin
      if (a[2*i +: 2] != 2'b11) n++;
      if (b[2*i +: 2] != 2'b11) n++;
      if (x[2*i +: 2] != 2'b11) n++;
    end
    return n;
  endfunction

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic load(input logic [1:0] sel, input logic [CODEW-1:0] data);
    @(negedge clk);
    loadEn = 1'b1; loadSel = sel; loadData = data;
    @(negedge clk);
    loadEn = 1'b0;
  endtask

  task automatic fire(input logic [SYMS-1:0] m);
    @(negedge clk);
    start = 1'b1; msgIn = m;
    @(negedge clk);
    start = 1'b0;
  endtask

  task automatic expectAll(input string req, input bit a, input logic [SYMS-1:0] nm, input int sp);
    chk({req, " valid"}, int'(outValid), 1);
    chk({req, " active"}, int'(active), int'(a));
    chk({req, " newMsg"}, int'(newMsg), int'(nm));
    chk({req, " specificity"}, int'(specificity), sp);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      errors++; checks++;
      $display("FAIL R6 watchdog actual=hung expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    logic [CODEW-1:0] a, b, x;
    repeat (3) @(negedge clk);
    // R9: reset state
    chk("R9 reset valid", int'(outValid), 0);
    chk("R9 reset active", int'(active), 0);
    chk("R9 reset newMsg", int'(newMsg), 0);
    chk("R9 reset specificity", int'(specificity), 0);
    rstN = 1'b1;
    // R9: stored strings are all don't-care after reset
    fire(8'h5A);
    expectAll("R9 post-reset", 1'b1, 8'h5A, 0);

    // R1 R2 R3 R5 R7: vector table
    for (int v = 0; v < 6; v++) begin
      a = enc(VEC[v][55:48], VEC[v][47:40]);
      b = enc(VEC[v][39:32], VEC[v][31:24]);
      x = enc(VEC[v][23:16], VEC[v][15:8]);
      load(2'd0, a);
      load(2'd1, b);
      load(2'd2, x);
      fire(VEC[v][7:0]);
      expectAll("R3 R5 R7 vector", modelActive(a, b, VEC[v][7:0]),
                modelMsg(x, VEC[v][7:0]), modelSpec(a, b, x));
      // R6: pulse lasts one cycle and outputs hold
      @(negedge clk);
      chk("R6 valid drops", int'(outValid), 0);
      chk("R6 active holds", int'(active), int'(modelActive(a, b, VEC[v][7:0])));
    end

    // R4: illegal 00 in a condition, R5: action 00 gives 0
    a = '1; a[1:0] = 2'b00;
    load(2'd0, a);
    load(2'd1, '1);
    load(2'd2, '0);
    fire(8'h00);
    expectAll("R4 illegal msg0", 1'b0, 8'h00, 9);
    fire(8'hFF);
    expectAll("R4 illegal msg1", 1'b0, 8'h00, 9);

    // R10: loadSel 3 writes nothing
    load(2'd0, '1);
    load(2'd2, '1);
    @(negedge clk);
    loadEn = 1'b1; loadSel = 2'd3; loadData = '0;
    @(negedge clk);
    loadEn = 1'b0;
    fire(8'hC3);
    expectAll("R10 sel3 ignored", 1'b1, 8'hC3, 0);

    // R8: load and start in the same cycle use the old contents
    @(negedge clk);
    loadEn = 1'b1; loadSel = 2'd0; loadData = enc(8'hFF, 8'h00);
    start = 1'b1; msgIn = 8'hFF;
    @(negedge clk);
    loadEn = 1'b0; start = 1'b0;
    expectAll("R8 same-cycle old", 1'b1, 8'hFF, 0);
    fire(8'hFF);
    expectAll("R8 same-cycle new", 1'b0, 8'hFF, 8);

    // R6: back-to-back starts keep valid high and update each cycle
    @(negedge clk);
    start = 1'b1; msgIn = 8'h00;
    @(negedge clk);
    msgIn = 8'h01;
    chk("R6 b2b first active", int'(active), 1);
    chk("R6 b2b first valid", int'(outValid), 1);
    @(negedge clk);
    start = 1'b0;
    chk("R6 b2b second active", int'(active), 0);
    chk("R6 b2b second newMsg", int'(newMsg), 8'h01);

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule